// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Encoder

This block is the digital back end of an 8-bit flash converter. A bank of 255 comparators presents a thermometer vector. Every comparator whose threshold lies below the analog input reads high, and every comparator above it reads low. On each rising edge of the convert clock the block captures that vector. It turns the vector into a binary count from 0 to 255 and registers the count as an output word.

Two static, active-low controls choose the output coding:

- One control flips the most significant bit.
- The other control flips the seven lower bits together.

With both controls high the output is offset binary. Flipping only the top bit gives twos complement. Flipping only the lower seven bits gives inverted twos complement. Flipping both gives inverted offset binary.

The comparator vector is captured on one convert edge. The formatted word appears on the output after the following edge, so the latency is one convert cycle. The word then holds steady until the next edge.

The encoder looks for the boundary between the run of ones and the zeros above it. It marks every position where a one sits directly below a zero. A comparator fault can create more than one such boundary. In that case the highest boundary decides the count.

Top module: `flash_therm_enc`

## Requirements
- R1: A clean thermometer vector with its lowest c bits high (bit 0 is the lowest threshold) encodes to the count c. With both controls high the output is c in plain binary.
- R2: The all-low vector encodes to 0 and the all-high vector encodes to 255. There is no wraparound at either end.
- R3: While `flip_msb_n` is low, output bit 7 is the inverse of bit 7 of the count. While it is high, bit 7 passes through unchanged.
- R4: While `flip_low_n` is low, output bits 6..0 are the inverse of bits 6..0 of the count. While it is high, they pass through unchanged.
- R5: A count of 128 reads as follows in the four codings. Both controls high gives 8'h80. Only `flip_msb_n` low gives 8'h00. Only `flip_low_n` low gives 8'hFF. Both controls low gives 8'h7F.
- R6: A vector present at convert edge N appears on `code_o` just after edge N+1. The output does not change before edge N+1. It stays constant while the input is held.
- R7: Position k counts as a boundary when the bit below k is high and bit k is low. An implied high sits below bit 0 and an implied low sits above bit 254. The count is the highest such position. A stray zero inside the run of ones leaves the count unchanged. A stray one at bit m above the run gives the count m+1.
- R8: A change on either control becomes visible on `code_o` at the first convert edge after the change.
- R9: While `rst` is high at a convert edge, both register stages clear. `code_o` then reads the encoding of a count of 0 under the controls present at that edge. The first word after reset is released is that same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_conv | input | 1 | Convert clock. All state changes on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| thermo_i | input | 255 | Comparator vector. Bit 0 holds the lowest threshold. |
| flip_msb_n | input | 1 | Active low. When low, output bit 7 is inverted. |
| flip_low_n | input | 1 | Active low. When low, output bits 6..0 are inverted. |
| code_o | output | 8 | Registered, formatted conversion word. |

## Verification
The comparator vector is due on `code_o` one edge after the edge that captures it. The bench therefore tags each vector it drives and sets a one-stage valid flag at the capture edge. It pops the expected word only on the next edge, sampling two nanoseconds after that edge.

A control change shows at the first edge after the change, and reset shows at the edge where `rst` is sampled high. The directed checks for these cases sample right after exactly that edge. They also sample one edge earlier, to confirm that nothing moved too soon.

Between the sweeps of the four codings the vector stream is drained. No word in flight is ever formatted under a control setting it was not tagged with.

// File: rtl/fenc_pkg.sv
package fenc_pkg;

  // Active-low format controls, grouped so they travel as one bundle.
  typedef struct packed {
    logic msb_keep_n;
    logic low_keep_n;
  } fmt_ctl_t;

  // XOR mask applied to the binary count: top bit from msb control,
  // all lower bits from the low control.
  function automatic logic [31:0] inv_mask(input fmt_ctl_t c, input int unsigned w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(w) - 1)       m[i] = ~c.low_keep_n;
      else if (i == int'(w) - 1) m[i] = ~c.msb_keep_n;
    end
    return m;
  endfunction

endpackage

// File: rtl/fenc_capture.sv
module fenc_capture #(
  parameter int N = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/fenc_edge_detect.sv
// Marks boundary positions: implied 1 below bit 0, implied 0 above the top.
module fenc_edge_detect #(
  parameter int W = 8,
  localparam int POS = 1 << W,
  localparam int N = POS - 1
) (
  input  logic [N-1:0]   t,
  output logic [POS-1:0] mark
);
  for (genvar k = 0; k < POS; k++) begin : g_pos
    if (k == 0) begin : g_bottom
      assign mark[k] = ~t[0];
    end else if (k == POS - 1) begin : g_top
      assign mark[k] = t[N-1];
    end else begin : g_mid
      assign mark[k] = t[k-1] & ~t[k];
    end
  end
endmodule

// File: rtl/fenc_prio_tree.sv
// Binary tree that returns the index of the highest set mark.
module fenc_prio_tree #(
  parameter int W = 8,
  localparam int POS = 1 << W
) (
  input  logic [POS-1:0] mark,
  output logic [W-1:0]   idx,
  output logic           found
);
  for (genvar l = 0; l <= W; l++) begin : lvl
    localparam int NODES = POS >> l;
    logic [NODES-1:0] v;
    logic [W-1:0]     ix [NODES];
    if (l == 0) begin : g_leaf
      assign v = mark;
      for (genvar n = 0; n < NODES; n++) begin : g_n
        assign ix[n] = '0;
      end
    end else begin : g_node
      localparam logic [W-1:0] HIBIT = W'(1) << (l - 1);
      for (genvar n = 0; n < NODES; n++) begin : g_n
        assign v[n]  = lvl[l-1].v[2*n] | lvl[l-1].v[2*n+1];
        assign ix[n] = lvl[l-1].v[2*n+1] ? (lvl[l-1].ix[2*n+1] | HIBIT)
                                         : lvl[l-1].ix[2*n];
      end
    end
  end

  assign idx   = lvl[W].ix[0];
  assign found = lvl[W].v[0];
endmodule

// File: rtl/fenc_format_reg.sv
module fenc_format_reg
  import fenc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code_i,
  input  fmt_ctl_t     ctl,
  output logic [W-1:0] q
);
  logic [W-1:0] mask;
  assign mask = W'(inv_mask(ctl, W));

  always_ff @(posedge clk) begin
    if (rst) q <= mask;
    else     q <= code_i ^ mask;
  end

  // R3: top output bit follows the count, flipped when the msb control is low
  assert_msb_flip_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[W-1] == ($past(code_i[W-1]) ^ ~$past(ctl.msb_keep_n))));

  // R4: lower bits follow the count, flipped together when the low control is low
  assert_low_flip_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[W-2:0] == ($past(code_i[W-2:0]) ^ {(W-1){~$past(ctl.low_keep_n)}})));

  // R9: a reset edge leaves the encoding of zero under the sampled controls
  assert_reset_zero_R9: assert property (@(posedge clk)
    rst |=> (q == {~$past(ctl.msb_keep_n), {(W-1){~$past(ctl.low_keep_n)}}}));
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
  import fenc_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int POS = 1 << CODE_W,
  localparam int N = POS - 1
) (
  input  logic              clk_conv,
  input  logic              rst,
  input  logic [N-1:0]      thermo_i,
  input  logic              flip_msb_n,
  input  logic              flip_low_n,
  output logic [CODE_W-1:0] code_o
);
  logic [N-1:0]      cap_q;
  logic [POS-1:0]    mark;
  logic [CODE_W-1:0] idx;
  logic              found;
  logic [CODE_W-1:0] enc_code;
  fmt_ctl_t          ctl;

  assign ctl.msb_keep_n = flip_msb_n;
  assign ctl.low_keep_n = flip_low_n;

  fenc_capture #(.N(N)) u_cap (
    .clk(clk_conv), .rst(rst), .d(thermo_i), .q(cap_q)
  );

  fenc_edge_detect #(.W(CODE_W)) u_edge (
    .t(cap_q), .mark(mark)
  );

  fenc_prio_tree #(.W(CODE_W)) u_tree (
    .mark(mark), .idx(idx), .found(found)
  );

  assign enc_code = found ? idx : '0;

  fenc_format_reg #(.W(CODE_W)) u_fmt (
    .clk(clk_conv), .rst(rst), .code_i(enc_code), .ctl(ctl), .q(code_o)
  );

  // R1: a clean captured thermometer yields its popcount one edge later
  assert_clean_count_R1: assert property (@(posedge clk_conv) disable iff (rst)
    (((cap_q & (cap_q + 1'b1)) == '0) && flip_msb_n && flip_low_n)
      |=> (code_o == CODE_W'($countones($past(cap_q)))));

  // R2: all-high vector saturates at full scale
  assert_top_scale_R2: assert property (@(posedge clk_conv) disable iff (rst)
    ((&cap_q) && flip_msb_n && flip_low_n) |=> (code_o == '1));

  // R2: all-low vector gives zero
  assert_bottom_scale_R2: assert property (@(posedge clk_conv) disable iff (rst)
    ((cap_q == '0) && flip_msb_n && flip_low_n) |=> (code_o == '0));
endmodule

// File: tb/sim_flash_therm_enc.sv
module sim_flash_therm_enc;
  localparam int W = 8;
  localparam int N = 255;

  typedef struct {
    logic [W-1:0] e;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] thermo;
  logic         fm_n, fl_n;
  logic [W-1:0] q;
  logic         drv_vld = 1'b0;
  bit           done = 1'b0;
  int           n_cmp = 0, n_bad = 0;
  item_t        sb[$];

  always #4 clk = ~clk;

  flash_therm_enc #(.CODE_W(W)) u0 (
    .clk_conv(clk), .rst(rst), .thermo_i(thermo),
    .flip_msb_n(fm_n), .flip_low_n(fl_n), .code_o(q)
  );

  function automatic logic [N-1:0] therm(int c);
    logic [N:0] x;
    x = (257'd1 << c) - 1;
    return x[N-1:0];
  endfunction

  function automatic logic [W-1:0] fmtx(int c, logic mn, logic ln);
    logic [W-1:0] v;
    v = c[W-1:0];
    if (!mn) v[W-1] = ~v[W-1];
    if (!ln) v[W-2:0] = ~v[W-2:0];
    return v;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(logic [N-1:0] t, int c, string tag);
    item_t it;
    @(negedge clk);
    thermo  = t;
    drv_vld = 1'b1;
    it.e    = fmtx(c, fm_n, fl_n);
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk) drv_vld = 1'b0;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  // Monitor: a vector captured at one edge is compared after the next edge.
  initial begin
    logic v1, old;
    v1 = 1'b0;
    forever begin
      @(posedge clk);
      old = v1;
      v1  = drv_vld;
      #2;
      if (old) begin
        if (sb.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6: output word with no expected item, got %h expected none", q);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, q, it.e);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] t;
    rst = 1'b1; thermo = therm(37); fm_n = 1'b1; fl_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 check("R9 reset value", q, fmtx(0, 1'b1, 1'b0));
    @(negedge clk) rst = 1'b0; thermo = '0;
    after_edge(); check("R9 first word after reset", q, fmtx(0, 1'b1, 1'b0));

    // R6 latency and hold, R2 bottom scale
    @(negedge clk) fl_n = 1'b1;
    after_edge(); after_edge();
    check("R2 all-low", q, 8'h00);
    @(negedge clk) thermo = therm(200);
    after_edge(); check("R6 not yet updated", q, 8'h00);
    after_edge(); check("R6 one cycle later", q, 8'd200);
    after_edge(); check("R6 held", q, 8'd200);

    // R8 control changes take effect at the next edge
    @(negedge clk) fl_n = 1'b0;
    after_edge(); check("R8 low flip applied", q, fmtx(200, 1'b1, 1'b0));
    @(negedge clk) fm_n = 1'b0;
    after_edge(); check("R8 msb flip applied", q, fmtx(200, 1'b0, 1'b0));
    idle(3);

    // Sweep all counts under all four codings
    for (int m = 3; m >= 0; m--) begin
      @(negedge clk) begin fm_n = m[1]; fl_n = m[0]; end
      for (int c = 0; c < 256; c++) begin
        string tag;
        if (c == 0 || c == 255) tag = "R2 full scale";
        else if (c == 128)      tag = "R5 mid code";
        else if (m == 3)        tag = "R1 count";
        else if (m == 1)        tag = "R3 msb flip";
        else if (m == 2)        tag = "R4 low flip";
        else                    tag = "R3 R4 both flipped";
        push(therm(c), c, tag);
      end
      idle(3);
    end

    // R7 bubbles: offset binary
    @(negedge clk) begin fm_n = 1'b1; fl_n = 1'b1; end
    t = therm(5);   t[2]   = 1'b0; push(t, 5,   "R7 hole in run");
    t = therm(100); t[50]  = 1'b0; push(t, 100, "R7 hole in run");
    t = therm(255); t[127] = 1'b0; push(t, 255, "R7 hole in full run");
    t = therm(10);  t[40]  = 1'b1; push(t, 41,  "R7 stray one above");
    t = '0;         t[254] = 1'b1; push(t, 255, "R7 stray top bit");
    idle(3);

    // R9 reset in the middle of traffic
    @(negedge clk) begin fm_n = 1'b0; fl_n = 1'b1; thermo = therm(77); end
    after_edge();
    @(negedge clk) rst = 1'b1;
    after_edge(); check("R9 reset mid-stream", q, fmtx(0, 1'b0, 1'b1));
    @(negedge clk) begin rst = 1'b0; thermo = therm(9); end
    after_edge(); check("R9 cleared capture stage", q, fmtx(0, 1'b0, 1'b1));
    after_edge(); check("R6 after reset release", q, fmtx(9, 1'b0, 1'b1));

    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R6: got %0d pending items expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule